// File: doc/BRIEF.md
# Increment-then-Subtract Memory Instruction Executor

This block carries out one fused read-modify-write instruction for an 8-bit accumulator processor. It bumps a byte in memory by one and writes it back. It then takes that new byte, plus the borrow implied by the carry flag, away from the accumulator. The surrounding core has already fetched the opcode and its one or two operand bytes. It hands them over with `start`, together with the current X, Y, accumulator and status byte. The block decodes the opcode into one of seven addressing modes and works out the effective address. It then runs the memory bus for a fixed number of cycles per mode, and finally returns the new accumulator and status byte with a single-cycle `done`.

The memory is single-port and synchronous: data read from the address presented in one cycle appears on `mem_rdata` in the next. In the read-modify-write phase, the unchanged byte is stored on one cycle and the incremented byte on the following cycle. When the decimal flag is set, the subtraction works on packed BCD.

The controller walks these states:
- **ST_IDLE**: waits for the next instruction.
- **ST_PAD**: covers the cycles that the address calculation takes.
- **ST_PTR_LO**, **ST_PTR_HI**, **ST_PTR_LATCH**: used only by the indirect modes. They present and then collect the two zero-page pointer bytes.
- **ST_READ**: presents the target address.
- **ST_MODIFY**: stores the original byte and registers the arithmetic result.
- **ST_WRITE**: stores the incremented byte and raises `done`.

The transitions are:
- ST_IDLE→ST_PAD on `start` with a recognised opcode.
- ST_PAD→ST_PAD while pad cycles remain.
- ST_PAD→ST_PTR_LO for the indirect modes, or ST_PAD→ST_READ for the others.
- ST_PTR_LO→ST_PTR_HI→ST_PTR_LATCH→ST_READ.
- ST_READ→ST_MODIFY→ST_WRITE→ST_IDLE.

Top module: `isc_exec`

## Requirements
- R1: Only opcodes 0xE7, 0xF7, 0xEF, 0xFF, 0xFB, 0xE3 and 0xF3 are accepted. A `start` with any other opcode causes no memory write and no `done`.
- R2: Counting the cycle in which `start` is sampled as cycle 1, `done` is high in cycle 5 for 0xE7, in cycle 6 for 0xF7 and 0xEF, in cycle 7 for 0xFF and 0xFB, and in cycle 8 for 0xE3 and 0xF3. The count is the same whether or not indexing crosses a page.
- R3: The effective address is formed as follows:
  - 0xE7: the operand low byte.
  - 0xF7: (low + X) mod 256 in page zero.
  - 0xEF: {high, low}.
  - 0xFF and 0xFB: {high, low} + X or + Y, carrying into the high byte.
  - 0xE3: a pointer read from zero-page bytes (low+X) mod 256 (low byte) and (low+X+1) mod 256 (high byte).
  - 0xF3: a pointer read from zero-page bytes low and (low+1) mod 256, plus Y as a 16-bit sum.
- R4: Exactly two writes go out, on consecutive cycles and both to the effective address. The first carries the original byte and the second carries the original byte plus one modulo 256, so 0xFF becomes 0x00.
- R5: With the decimal flag (status bit 3) clear, the new accumulator is A − M' − (1 − C), where M' is the incremented byte and C is status bit 0. C becomes 1 when no borrow occurs. V (bit 6) is set on signed overflow of the subtraction.
- R6: N (bit 7) copies bit 7 of the binary difference. Z (bit 1) is set when the binary difference is zero. This holds in both arithmetic modes.
- R7: With the decimal flag set and valid BCD operands, the accumulator receives the packed BCD difference modulo 100. C is 1 when the decimal difference did not go below zero.
- R8: Status bits 5, 4, 3 and 2 leave the block unchanged.
- R9: `done` is high for exactly one cycle, which is the cycle of the second write. `acc_out` and `flags_out` are valid in that cycle and hold their values until the next instruction.
- R10: While reset is low, and afterwards until a `start`, `done` and `mem_we` are low, and `acc_out` and `flags_out` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction using the values below |
| opcode | input | 8 | Opcode byte |
| oper_lo | input | 8 | First operand byte |
| oper_hi | input | 8 | Second operand byte (absolute modes) |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| acc_in | input | 8 | Accumulator before the instruction |
| flags_in | input | 8 | Status byte before the instruction |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Read data, one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| done | output | 1 | Final-cycle strobe |
| acc_out | output | 8 | Accumulator after the instruction |
| flags_out | output | 8 | Status byte after the instruction |

## Verification
A wrong state or a wrong pad count moves the cycle in which `done` appears. It also moves the pair of write strobes, and both are visible at the ports on the very instruction that went wrong. A pointer byte latched from the wrong cycle sends both writes to a wrong address, which shows up within the same eight cycles. A mistake in the arithmetic appears on `acc_out` or `flags_out` in the `done` cycle itself, because the result is registered one cycle earlier. The vectors cover every mode, page wrap and page crossing, the 0xFF rollover, and both arithmetic modes, so each of these faults changes at least one sampled value.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2 * DATA_W;
    localparam int CYC_W  = 4;
    localparam int PAD_W  = 3;

    localparam int FLG_N = 7;
    localparam int FLG_V = 6;
    localparam int FLG_D = 3;
    localparam int FLG_Z = 1;
    localparam int FLG_C = 0;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        AM_ZP, AM_ZPX, AM_ABS, AM_ABSX, AM_ABSY, AM_INDX, AM_INDY
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PAD, ST_PTR_LO, ST_PTR_HI, ST_PTR_LATCH,
        ST_READ, ST_MODIFY, ST_WRITE
    } state_e;
endpackage

// File: rtl/isc_decode.sv
module isc_decode
    import isc_pkg::*;
(
    input  byte_t            opcode,
    output logic             hit,
    output amode_e           mode,
    output logic [CYC_W-1:0] cycles,
    output logic             indirect
);
    always_comb begin
        hit    = 1'b1;
        mode   = AM_ZP;
        cycles = CYC_W'(5);
        unique case (opcode)
            8'hE7: begin mode = AM_ZP;   cycles = CYC_W'(5); end
            8'hF7: begin mode = AM_ZPX;  cycles = CYC_W'(6); end
            8'hEF: begin mode = AM_ABS;  cycles = CYC_W'(6); end
            8'hFF: begin mode = AM_ABSX; cycles = CYC_W'(7); end
            8'hFB: begin mode = AM_ABSY; cycles = CYC_W'(7); end
            8'hE3: begin mode = AM_INDX; cycles = CYC_W'(8); end
            8'hF3: begin mode = AM_INDY; cycles = CYC_W'(8); end
            default: hit = 1'b0;
        endcase
        indirect = hit && ((mode == AM_INDX) || (mode == AM_INDY));
    end

    // R2: an indirect mode always needs the longest sequence
    always_comb begin
        if (indirect) begin
            assert_indirect_len_R2: assert (cycles == CYC_W'(8));
        end
    end
endmodule

// File: rtl/isc_agen.sv
module isc_agen
    import isc_pkg::*;
(
    input  amode_e mode,
    input  byte_t  lo,
    input  byte_t  hi,
    input  byte_t  x,
    input  byte_t  y,
    input  byte_t  ptr_lo,
    input  byte_t  ptr_hi,
    output byte_t  ptr_a0,
    output byte_t  ptr_a1,
    output addr_t  ea
);
    localparam byte_t ZERO = '0;

    byte_t zp_sum;
    addr_t abs_base;
    addr_t ptr_base;

    always_comb begin
        zp_sum   = lo + x;
        abs_base = {hi, lo};
        ptr_base = {ptr_hi, ptr_lo};
        ptr_a0   = (mode == AM_INDX) ? zp_sum : lo;
        ptr_a1   = ptr_a0 + byte_t'(1);
        unique case (mode)
            AM_ZP:   ea = {ZERO, lo};
            AM_ZPX:  ea = {ZERO, zp_sum};
            AM_ABS:  ea = abs_base;
            AM_ABSX: ea = abs_base + {ZERO, x};
            AM_ABSY: ea = abs_base + {ZERO, y};
            AM_INDX: ea = ptr_base;
            AM_INDY: ea = ptr_base + {ZERO, y};
            default: ea = abs_base;
        endcase
    end
endmodule

// File: rtl/isc_sbc.sv
module isc_sbc
    import isc_pkg::*;
(
    input  byte_t a,
    input  byte_t m,
    input  logic  c_in,
    input  logic  dec_en,
    output byte_t res,
    output logic  n_out,
    output logic  v_out,
    output logic  z_out,
    output logic  c_out
);
    localparam int NIB = DATA_W / 2;

    logic              borrow;
    logic [DATA_W:0]   diff_bin;
    byte_t             bin_res;
    logic [NIB:0]      lo_d;
    logic [NIB:0]      hi_d;
    logic              lo_neg;
    logic              hi_neg;
    logic [NIB-1:0]    lo_fix;
    logic [NIB-1:0]    hi_fix;

    always_comb begin
        borrow   = ~c_in;
        diff_bin = {1'b0, a} - {1'b0, m} - {{DATA_W{1'b0}}, borrow};
        bin_res  = diff_bin[DATA_W-1:0];

        lo_d   = {1'b0, a[NIB-1:0]} - {1'b0, m[NIB-1:0]} - {{NIB{1'b0}}, borrow};
        lo_neg = lo_d[NIB];
        hi_d   = {1'b0, a[DATA_W-1:NIB]} - {1'b0, m[DATA_W-1:NIB]} - {{NIB{1'b0}}, lo_neg};
        hi_neg = hi_d[NIB];
        lo_fix = lo_neg ? (lo_d[NIB-1:0] - NIB'(6)) : lo_d[NIB-1:0];
        hi_fix = hi_neg ? (hi_d[NIB-1:0] - NIB'(6)) : hi_d[NIB-1:0];

        n_out = bin_res[DATA_W-1];
        z_out = (bin_res == '0);
        v_out = ((a[DATA_W-1] ^ m[DATA_W-1]) & (a[DATA_W-1] ^ bin_res[DATA_W-1]));
        if (dec_en) begin
            res   = {hi_fix, lo_fix};
            c_out = ~hi_neg;
        end else begin
            res   = bin_res;
            c_out = ~diff_bin[DATA_W];
        end
    end

    // R5: adding the subtrahend and borrow back must restore A
    always_comb begin
        if (!dec_en) begin
            assert_bin_diff_R5: assert (byte_t'(res + m + {{(DATA_W-1){1'b0}}, borrow}) == a);
        end
    end
endmodule

// File: rtl/isc_exec.sv
module isc_exec
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] opcode,
    input  logic [DATA_W-1:0] oper_lo,
    input  logic [DATA_W-1:0] oper_hi,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] flags_in,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              done,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] flags_out
);
    localparam byte_t ZERO = '0;

    state_e           state, state_nx;
    amode_e           mode_r;
    byte_t            lo_r, hi_r, x_r, y_r, acc_r, flg_r;
    byte_t            ptr_lo_r, ptr_hi_r, data_r;
    logic             ind_r;
    logic [PAD_W-1:0] pad_r;
    logic [CYC_W-1:0] cyc_need_r, cyc_cnt_r;

    logic             dec_hit, dec_ind;
    amode_e           dec_mode;
    logic [CYC_W-1:0] dec_cycles;
    logic             accept;

    byte_t            ptr_a0, ptr_a1;
    addr_t            ea;
    byte_t            m_inc;
    byte_t            alu_res;
    logic             alu_n, alu_v, alu_z, alu_c;
    byte_t            flg_next;

    isc_decode u_decode (
        .opcode   (opcode),
        .hit      (dec_hit),
        .mode     (dec_mode),
        .cycles   (dec_cycles),
        .indirect (dec_ind)
    );

    isc_agen u_agen (
        .mode   (mode_r),
        .lo     (lo_r),
        .hi     (hi_r),
        .x      (x_r),
        .y      (y_r),
        .ptr_lo (ptr_lo_r),
        .ptr_hi (ptr_hi_r),
        .ptr_a0 (ptr_a0),
        .ptr_a1 (ptr_a1),
        .ea     (ea)
    );

    assign m_inc = mem_rdata + byte_t'(1);

    isc_sbc u_sbc (
        .a      (acc_r),
        .m      (m_inc),
        .c_in   (flg_r[FLG_C]),
        .dec_en (flg_r[FLG_D]),
        .res    (alu_res),
        .n_out  (alu_n),
        .v_out  (alu_v),
        .z_out  (alu_z),
        .c_out  (alu_c)
    );

    always_comb begin
        flg_next        = flg_r;
        flg_next[FLG_N] = alu_n;
        flg_next[FLG_V] = alu_v;
        flg_next[FLG_Z] = alu_z;
        flg_next[FLG_C] = alu_c;
    end

    assign accept = (state == ST_IDLE) && start && dec_hit;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (accept) state_nx = ST_PAD;
            ST_PAD:       if (pad_r == PAD_W'(1)) state_nx = ind_r ? ST_PTR_LO : ST_READ;
            ST_PTR_LO:    state_nx = ST_PTR_HI;
            ST_PTR_HI:    state_nx = ST_PTR_LATCH;
            ST_PTR_LATCH: state_nx = ST_READ;
            ST_READ:      state_nx = ST_MODIFY;
            ST_MODIFY:    state_nx = ST_WRITE;
            ST_WRITE:     state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r     <= AM_ZP;
            lo_r       <= '0;
            hi_r       <= '0;
            x_r        <= '0;
            y_r        <= '0;
            acc_r      <= '0;
            flg_r      <= '0;
            ind_r      <= 1'b0;
            pad_r      <= '0;
            ptr_lo_r   <= '0;
            ptr_hi_r   <= '0;
            data_r     <= '0;
            acc_out    <= '0;
            flags_out  <= '0;
            cyc_need_r <= '0;
            cyc_cnt_r  <= '0;
        end else begin
            if (accept) begin
                mode_r     <= dec_mode;
                lo_r       <= oper_lo;
                hi_r       <= oper_hi;
                x_r        <= x_in;
                y_r        <= y_in;
                acc_r      <= acc_in;
                flg_r      <= flags_in;
                ind_r      <= dec_ind;
                pad_r      <= dec_ind ? PAD_W'(1) : PAD_W'(dec_cycles - CYC_W'(4));
                cyc_need_r <= dec_cycles;
                cyc_cnt_r  <= CYC_W'(2);
            end else if (state != ST_IDLE) begin
                cyc_cnt_r <= cyc_cnt_r + CYC_W'(1);
            end
            unique case (state)
                ST_PAD:       pad_r    <= pad_r - PAD_W'(1);
                ST_PTR_HI:    ptr_lo_r <= mem_rdata;
                ST_PTR_LATCH: ptr_hi_r <= mem_rdata;
                ST_MODIFY: begin
                    data_r    <= m_inc;
                    acc_out   <= alu_res;
                    flags_out <= flg_next;
                end
                default: ;
            endcase
        end
    end

    // bus and strobe outputs
    always_comb begin
        mem_addr  = ea;
        mem_wdata = data_r;
        mem_we    = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_PTR_LO: mem_addr = {ZERO, ptr_a0};
            ST_PTR_HI: mem_addr = {ZERO, ptr_a1};
            ST_MODIFY: begin
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            ST_WRITE: begin
                mem_we = 1'b1;
                done   = 1'b1;
            end
            default: ;
        endcase
    end

    // R4: the second write follows at the same address with the byte plus one
    assert_rmw_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> mem_we && $stable(mem_addr)
                          && (mem_wdata == byte_t'($past(mem_wdata) + byte_t'(1))));

    // R4: no third write in a row
    assert_write_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |=> !mem_we);

    // R9: done lasts one cycle and lands on the second write
    assert_done_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_we && $past(mem_we));

    // R2: final cycle matches the mode's cycle count
    assert_cycle_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_cnt_r == cyc_need_r));

    // R8: bits outside N, V, Z, C come through unchanged
    assert_flags_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[5:2] == flg_r[5:2]));
endmodule

// File: tb/isc_exec_bench.sv
module isc_exec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, oper_lo = '0, oper_hi = '0, x_in = '0, y_in = '0, acc_in = '0, flags_in = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        done;
    logic [7:0]  acc_out, flags_out;

    logic [7:0]  mem [4096];
    logic        tb_we = 1'b0;
    logic [11:0] tb_addr = '0;
    logic [7:0]  tb_wdata = '0;

    logic        log_clr = 1'b0;
    int          wr_cnt = 0;
    logic [7:0]  first_w = '0;
    logic        bad_addr = 1'b0;
    logic [15:0] exp_ea = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isc_exec u_isc_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .oper_lo(oper_lo), .oper_hi(oper_hi), .x_in(x_in), .y_in(y_in),
        .acc_in(acc_in), .flags_in(flags_in), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .done(done), .acc_out(acc_out), .flags_out(flags_out)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        else if (tb_we) mem[tb_addr] <= tb_wdata;
        mem_rdata <= mem[mem_addr[11:0]];
    end

    always @(posedge clk) begin
        if (log_clr) begin
            wr_cnt = 0; bad_addr = 1'b0; first_w = '0;
        end else if (mem_we) begin
            if (wr_cnt == 0) first_w = mem_wdata;
            if (mem_addr != exp_ea) bad_addr = 1'b1;
            wr_cnt = wr_cnt + 1;
        end
    end

    // op, lo, hi, x, y, a, p, m, cycles
    localparam logic [71:0] VECS [NV] = '{
        72'hE7_10_00_00_00_50_01_0F_05,
        72'hF7_F0_00_20_00_00_00_FF_06,
        72'hEF_34_02_00_00_80_01_00_06,
        72'hFF_F0_01_20_00_10_01_0F_07,
        72'hFB_00_03_00_05_20_35_30_07,
        72'hE3_FE_04_01_00_99_09_44_08,
        72'hF3_20_05_00_90_12_08_33_08,
        72'hE7_30_00_00_00_00_0B_FF_05,
        72'hF7_40_00_05_00_50_29_08_06,
        72'hEF_56_02_00_00_7F_00_7F_06,
        72'hFF_00_07_FF_00_10_09_08_07,
        72'hE3_10_06_05_00_05_01_04_08
    };

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // independent reference: integer arithmetic and decimal digit values
    function automatic logic [15:0] ref_model(input logic [7:0] a, input logic [7:0] m,
                                              input logic [7:0] p);
        int diff, da, dm, dd;
        logic [7:0] r, ra, po;
        diff = int'(a) - int'(m) - (p[0] ? 0 : 1);
        r = 8'(diff & 255);
        po = p;
        po[7] = r[7];
        po[1] = (r == 8'h00);
        po[6] = ((a ^ m) & (a ^ r) & 8'h80) != 8'h00;
        ra = r;
        po[0] = (diff >= 0);
        if (p[3]) begin
            da = int'(a[7:4]) * 10 + int'(a[3:0]);
            dm = int'(m[7:4]) * 10 + int'(m[3:0]);
            dd = da - dm - (p[0] ? 0 : 1);
            po[0] = (dd >= 0);
            if (dd < 0) dd = dd + 100;
            ra = {4'(dd / 10), 4'(dd % 10)};
        end
        return {ra, po};
    endfunction

    task automatic poke(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a; tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic run_vec(input logic [71:0] v, input int idx);
        logic [7:0] op, lo, hi, xv, yv, av, pv, mv, ptr;
        logic [15:0] ea, expv;
        int cyc, cnt;
        logic got;
        logic [7:0] held_a;
        {op, lo, hi, xv, yv, av, pv, mv} = v[71:8];
        cyc = int'(v[7:0]);
        ptr = 8'h00;
        case (op)
            8'hE7: ea = {8'h00, lo};
            8'hF7: ea = {8'h00, 8'(lo + xv)};
            8'hEF: ea = {hi, lo};
            8'hFF: ea = {hi, lo} + {8'h00, xv};
            8'hFB: ea = {hi, lo} + {8'h00, yv};
            8'hE3: begin ptr = 8'(lo + xv); ea = {hi, 8'h80}; end
            default: begin ptr = lo; ea = {hi, 8'h80} + {8'h00, yv}; end
        endcase
        if (op == 8'hE3 || op == 8'hF3) begin
            poke({4'h0, ptr}, 8'h80);
            poke({4'h0, 8'(ptr + 8'h01)}, hi);
        end
        poke(ea[11:0], mv);
        exp_ea = ea;
        expv = ref_model(av, 8'(mv + 8'h01), pv);
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        start = 1'b1; opcode = op; oper_lo = lo; oper_hi = hi;
        x_in = xv; y_in = yv; acc_in = av; flags_in = pv;
        @(posedge clk);
        cnt = 1; got = 1'b0;
        while (!got && cnt < 40) begin
            @(negedge clk);
            start = 1'b0;
            cnt++;
            if (done) got = 1'b1;
        end
        // R2: done cycle per mode
        chk(got && cnt == cyc, "R2", $sformatf("vec%0d done cycle", idx), cnt, cyc);
        // R5 R6 R7: accumulator and flags in the done cycle
        chk(acc_out == expv[15:8], pv[3] ? "R7" : "R5", $sformatf("vec%0d acc", idx),
            acc_out, expv[15:8]);
        chk(flags_out[7:6] == expv[7:6] && flags_out[1:0] == expv[1:0], "R6",
            $sformatf("vec%0d NVZC", idx), flags_out, expv[7:0]);
        // R8: untouched bits
        chk(flags_out[5:2] == pv[5:2], "R8", $sformatf("vec%0d other flags", idx),
            flags_out, pv);
        held_a = acc_out;
        @(negedge clk);
        // R9: single-cycle strobe, results held
        chk(!done && acc_out == held_a, "R9", $sformatf("vec%0d done/hold", idx),
            {done, acc_out}, {1'b0, held_a});
        // R4: two writes, original then incremented
        chk(wr_cnt == 2 && first_w == mv, "R4", $sformatf("vec%0d write pair", idx),
            {wr_cnt[7:0], first_w}, {8'd2, mv});
        chk(mem[ea[11:0]] == 8'(mv + 8'h01), "R4", $sformatf("vec%0d stored byte", idx),
            mem[ea[11:0]], 8'(mv + 8'h01));
        // R3: all writes at the computed effective address
        chk(!bad_addr, "R3", $sformatf("vec%0d address", idx), mem_addr, ea);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic seen_done;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!done && !mem_we, "R10", "strobes in reset", {done, mem_we}, 0);
        chk(acc_out == 8'h00 && flags_out == 8'h00, "R10", "results in reset",
            {acc_out, flags_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_we, "R10", "strobes after reset", {done, mem_we}, 0);

        // R1: unrecognised opcodes ignored
        foreach (VECS[i]) begin end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); log_clr = 1'b1;
            @(negedge clk); log_clr = 1'b0;
            exp_ea = 16'hFFFF;
            start = 1'b1; opcode = (k == 0) ? 8'hE9 : 8'hEB; oper_lo = 8'h10;
            @(negedge clk); start = 1'b0;
            seen_done = 1'b0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (done) seen_done = 1'b1;
            end
            chk(!seen_done && wr_cnt == 0, "R1", $sformatf("opcode 0x%0h ignored", opcode),
                {seen_done, wr_cnt[7:0]}, 0);
        end

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule